// File: doc/BRIEF.md
# Multiplexed Address/Data External Memory Bus Controller

This controller turns single read or write requests from inside the chip into bus cycles for an external 64K x 8 memory. The low address byte and the data byte share one 8-bit port. That port is presented as three signals: a value to drive, an output enable and the sampled input. The pad ring combines them into one bidirectional pin group. The high address byte has a dedicated output.

Each access has two phases. In the first phase, an address-latch strobe is high and the low address byte is driven, so that an external transparent latch follows it. The latch freezes when the strobe falls. In the second phase, the same port carries data while the active-low read or write strobe is asserted. All phase lengths are fixed parameters counted in clock cycles.

On the internal side, a request is accepted only while the controller reports idle. A single-cycle completion pulse marks the end of every access, and for reads the captured byte is valid in that same cycle.

Top module: `muxbus_ctrl`

## Requirements
- R1: After reset, `req_idle` is 1, `ale` is 0, `rd_n` and `wr_n` are 1, `ad_oe` is 0 and `done` is 0.
- R2: A request is taken only in a cycle where `req_idle` is 1. A `req_valid` raised while an access is in progress, including the completion cycle, starts no bus cycle and does not alter the access in flight.
- R3: An access begins with `ale` high for exactly ALE_CYC cycles. During those cycles `ad_out` carries address bits [7:0] with `ad_oe` at 1, and `a_hi` carries address bits [15:8].
- R4: After `ale` falls, the port keeps driving the same low address byte, and `a_hi` keeps its value, for AHOLD_CYC (at least 1) cycles.
- R5: `rd_n` and `wr_n` are never 0 in the same cycle, and neither is 0 while `ale` is 1.
- R6: For a read, `ad_oe` is 0 for TURN_CYC (at least 1) cycles before `rd_n` falls and stays 0 while `rd_n` is 0. `rd_n` is 0 for exactly STRB_CYC cycles, and `ad_in` is sampled on the last of them.
- R7: For a write, `wr_n` is 0 for exactly STRB_CYC cycles with `ad_out` equal to the write data and `ad_oe` at 1. Both stay unchanged for WHOLD_CYC cycles after `wr_n` returns to 1.
- R8: `a_hi` keeps one value from the first `ale` cycle until the access completes.
- R9: `done` is high for exactly one cycle per access. For a read, `rd_data` holds the sampled byte in that cycle. The cycle count from acceptance to `done` is ALE_CYC+AHOLD_CYC+TURN_CYC+STRB_CYC+1 for reads and ALE_CYC+AHOLD_CYC+STRB_CYC+WHOLD_CYC+1 for writes.
- R10: While `req_idle` is 1, `ad_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Byte address |
| req_wdata | input | 8 | Write byte |
| req_idle | output | 1 | Controller can take a request this cycle |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 8 | Read byte, valid with `done` after a read |
| ad_out | output | 8 | Value driven on the shared address/data port |
| ad_oe | output | 1 | Drive enable for the shared port |
| ad_in | input | 8 | Value sampled from the shared port |
| a_hi | output | 8 | High address byte |
| ale | output | 1 | Address latch strobe, high in the address phase |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |

## Verification
The completion pulse of one access and the arrival of the next request can fall in the same cycle. The bench provokes this by raising `req_valid` for a new access at the sampling point where `done` is seen. It then judges that the following cycle is still idle with `ale` low, and that `ale` rises one cycle later. Random traffic also raises junk requests in the middle of accesses. For those accesses the bench confirms that the external latch model still captures the original address and that no extra bus cycle follows.

// File: rtl/muxbus_pkg.sv
package muxbus_pkg;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_ALE   = 3'd1,
        PH_AHOLD = 3'd2,
        PH_TURN  = 3'd3,
        PH_STRB  = 3'd4,
        PH_WHOLD = 3'd5,
        PH_DONE  = 3'd6
    } phase_e;

    // Counter width able to hold the longest phase length minus one.
    function automatic int unsigned phase_cnt_bits(
        input int unsigned a, input int unsigned b, input int unsigned c,
        input int unsigned d, input int unsigned e);
        int unsigned m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        if (e > m) m = e;
        return (m > 1) ? $clog2(m) : 1;
    endfunction

endpackage

// File: rtl/muxbus_seq.sv
module muxbus_seq
    import muxbus_pkg::*;
#(
    parameter int unsigned AW        = 16,
    parameter int unsigned DW        = 8,
    parameter int unsigned ALE_CYC   = 2,
    parameter int unsigned AHOLD_CYC = 1,
    parameter int unsigned TURN_CYC  = 1,
    parameter int unsigned STRB_CYC  = 3,
    parameter int unsigned WHOLD_CYC = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output phase_e        ph_q,
    output phase_e        ph_d,
    output logic          ph_last,
    output logic [AW-1:0] addr_d,
    output logic [DW-1:0] wdata_d,
    output logic          wr_d,
    output logic          wr_q
);
    localparam int unsigned CW =
        phase_cnt_bits(ALE_CYC, AHOLD_CYC, TURN_CYC, STRB_CYC, WHOLD_CYC);

    typedef struct packed {
        phase_e        ph;
        logic [CW-1:0] cnt;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
        logic          wr;
    } seq_t;

    seq_t s_d, s_q;

    function automatic logic [CW-1:0] len_m1(input int unsigned n);
        return CW'(n - 1);
    endfunction

    always_comb begin
        s_d     = s_q;
        ph_last = (s_q.cnt == '0);
        unique case (s_q.ph)
            PH_IDLE: begin
                if (req_valid) begin
                    s_d.ph    = PH_ALE;
                    s_d.cnt   = len_m1(ALE_CYC);
                    s_d.addr  = req_addr;
                    s_d.wdata = req_wdata;
                    s_d.wr    = req_write;
                end
            end
            PH_ALE: begin
                if (!ph_last) begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end else begin
                    s_d.ph  = PH_AHOLD;
                    s_d.cnt = len_m1(AHOLD_CYC);
                end
            end
            PH_AHOLD: begin
                if (!ph_last) begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end else if (s_q.wr) begin
                    s_d.ph  = PH_STRB;
                    s_d.cnt = len_m1(STRB_CYC);
                end else begin
                    s_d.ph  = PH_TURN;
                    s_d.cnt = len_m1(TURN_CYC);
                end
            end
            PH_TURN: begin
                if (!ph_last) begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end else begin
                    s_d.ph  = PH_STRB;
                    s_d.cnt = len_m1(STRB_CYC);
                end
            end
            PH_STRB: begin
                if (!ph_last) begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end else if (s_q.wr) begin
                    s_d.ph  = PH_WHOLD;
                    s_d.cnt = len_m1(WHOLD_CYC);
                end else begin
                    s_d.ph  = PH_DONE;
                    s_d.cnt = '0;
                end
            end
            PH_WHOLD: begin
                if (!ph_last) begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end else begin
                    s_d.ph  = PH_DONE;
                    s_d.cnt = '0;
                end
            end
            PH_DONE: begin
                s_d.ph  = PH_IDLE;
                s_d.cnt = '0;
            end
            default: begin
                s_d.ph  = PH_IDLE;
                s_d.cnt = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign ph_q    = s_q.ph;
    assign ph_d    = s_d.ph;
    assign addr_d  = s_d.addr;
    assign wdata_d = s_d.wdata;
    assign wr_d    = s_d.wr;
    assign wr_q    = s_q.wr;

endmodule

// File: rtl/muxbus_drv.sv
module muxbus_drv
    import muxbus_pkg::*;
#(
    parameter int unsigned AW = 16,
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  phase_e        ph_d,
    input  logic [AW-1:0] addr_d,
    input  logic [DW-1:0] wdata_d,
    input  logic          wr_d,
    output logic          ale,
    output logic          rd_n,
    output logic          wr_n,
    output logic          ad_oe,
    output logic [DW-1:0] ad_out,
    output logic [AW-DW-1:0] a_hi
);
    localparam int unsigned HW = AW - DW;

    typedef struct packed {
        logic          ale;
        logic          rd_n;
        logic          wr_n;
        logic          oe;
        logic [DW-1:0] dout;
        logic [HW-1:0] ahi;
    } pins_t;

    pins_t p_d, p_q;
    logic  addr_ph;
    logic  data_ph;

    // Pin values are registered from the sequencer's next phase so they
    // line up with the registered phase and carry no decode glitches.
    always_comb begin
        p_d     = p_q;
        addr_ph = (ph_d == PH_ALE) || (ph_d == PH_AHOLD);
        data_ph = wr_d && ((ph_d == PH_STRB) || (ph_d == PH_WHOLD));

        p_d.ale  = (ph_d == PH_ALE);
        p_d.rd_n = !((ph_d == PH_STRB) && !wr_d);
        p_d.wr_n = !((ph_d == PH_STRB) && wr_d);
        p_d.oe   = addr_ph || data_ph;

        if (addr_ph)      p_d.dout = addr_d[DW-1:0];
        else if (data_ph) p_d.dout = wdata_d;

        if (ph_d == PH_ALE) p_d.ahi = addr_d[AW-1:DW];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p_q      <= '0;
            p_q.rd_n <= 1'b1;
            p_q.wr_n <= 1'b1;
        end else begin
            p_q <= p_d;
        end
    end

    assign ale    = p_q.ale;
    assign rd_n   = p_q.rd_n;
    assign wr_n   = p_q.wr_n;
    assign ad_oe  = p_q.oe;
    assign ad_out = p_q.dout;
    assign a_hi   = p_q.ahi;

endmodule

// File: rtl/muxbus_rdcap.sv
module muxbus_rdcap
    import muxbus_pkg::*;
#(
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  phase_e        ph_q,
    input  phase_e        ph_d,
    input  logic          ph_last,
    input  logic          wr_q,
    input  logic [DW-1:0] ad_in,
    output logic [DW-1:0] rd_data,
    output logic          done
);
    typedef struct packed {
        logic          done;
        logic [DW-1:0] data;
    } cap_t;

    cap_t c_d, c_q;

    always_comb begin
        c_d      = c_q;
        c_d.done = (ph_d == PH_DONE);
        if ((ph_q == PH_STRB) && ph_last && !wr_q) c_d.data = ad_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign rd_data = c_q.data;
    assign done    = c_q.done;

endmodule

// File: rtl/muxbus_ctrl.sv
module muxbus_ctrl
    import muxbus_pkg::*;
#(
    parameter int unsigned AW        = 16,
    parameter int unsigned DW        = 8,
    parameter int unsigned ALE_CYC   = 2,
    parameter int unsigned AHOLD_CYC = 1,
    parameter int unsigned TURN_CYC  = 1,
    parameter int unsigned STRB_CYC  = 3,
    parameter int unsigned WHOLD_CYC = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [AW-1:0]    req_addr,
    input  logic [DW-1:0]    req_wdata,
    output logic             req_idle,
    output logic             done,
    output logic [DW-1:0]    rd_data,
    output logic [DW-1:0]    ad_out,
    output logic             ad_oe,
    input  logic [DW-1:0]    ad_in,
    output logic [AW-DW-1:0] a_hi,
    output logic             ale,
    output logic             rd_n,
    output logic             wr_n
);
    phase_e        ph_q;
    phase_e        ph_d;
    logic          ph_last;
    logic [AW-1:0] addr_d;
    logic [DW-1:0] wdata_d;
    logic          wr_d;
    logic          wr_q;

    muxbus_seq #(
        .AW(AW), .DW(DW), .ALE_CYC(ALE_CYC), .AHOLD_CYC(AHOLD_CYC),
        .TURN_CYC(TURN_CYC), .STRB_CYC(STRB_CYC), .WHOLD_CYC(WHOLD_CYC)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_valid(req_valid),
        .req_write(req_write),
        .req_addr (req_addr),
        .req_wdata(req_wdata),
        .ph_q     (ph_q),
        .ph_d     (ph_d),
        .ph_last  (ph_last),
        .addr_d   (addr_d),
        .wdata_d  (wdata_d),
        .wr_d     (wr_d),
        .wr_q     (wr_q)
    );

    muxbus_drv #(.AW(AW), .DW(DW)) u_drv (
        .clk    (clk),
        .rst_n  (rst_n),
        .ph_d   (ph_d),
        .addr_d (addr_d),
        .wdata_d(wdata_d),
        .wr_d   (wr_d),
        .ale    (ale),
        .rd_n   (rd_n),
        .wr_n   (wr_n),
        .ad_oe  (ad_oe),
        .ad_out (ad_out),
        .a_hi   (a_hi)
    );

    muxbus_rdcap #(.DW(DW)) u_cap (
        .clk    (clk),
        .rst_n  (rst_n),
        .ph_q   (ph_q),
        .ph_d   (ph_d),
        .ph_last(ph_last),
        .wr_q   (wr_q),
        .ad_in  (ad_in),
        .rd_data(rd_data),
        .done   (done)
    );

    assign req_idle = (ph_q == PH_IDLE);

endmodule

// File: rtl/muxbus_chk.sv
module muxbus_chk #(
    parameter int unsigned AW = 16,
    parameter int unsigned DW = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_idle,
    input logic             done,
    input logic             ale,
    input logic             rd_n,
    input logic             wr_n,
    input logic             ad_oe,
    input logic [DW-1:0]    ad_out,
    input logic [AW-DW-1:0] a_hi
);
    p_start_from_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ale) |-> $past(req_idle));

    p_ale_drives_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ale |-> ad_oe);

    p_addr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ale) |-> (ad_oe && $stable(ad_out) && $stable(a_hi)));

    p_strobe_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !wr_n));

    p_no_strobe_in_ale_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ale |-> (rd_n && wr_n));

    p_turn_before_rd_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rd_n) |-> (!ad_oe && $past(!ad_oe)));

    p_released_in_rd_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> !ad_oe);

    p_drive_in_wr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n |-> ad_oe);

    p_wr_data_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_n) |-> (ad_oe && $stable(ad_out)));

    p_ahi_steady_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_idle && $past(!req_idle)) |-> $stable(a_hi));

    p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        req_idle |-> (!ad_oe && rd_n && wr_n && !ale));

endmodule

bind muxbus_ctrl muxbus_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .req_idle(req_idle),
    .done    (done),
    .ale     (ale),
    .rd_n    (rd_n),
    .wr_n    (wr_n),
    .ad_oe   (ad_oe),
    .ad_out  (ad_out),
    .a_hi    (a_hi)
);

// File: tb/sim_muxbus_ctrl.sv
`timescale 1ns/1ps
module sim_muxbus_ctrl;
    localparam int ALE_C = 2;
    localparam int AH_C  = 1;
    localparam int TR_C  = 1;
    localparam int ST_C  = 3;
    localparam int WH_C  = 1;
    localparam int WD_LIMIT = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        req_idle, done, ale, rd_n, wr_n, ad_oe;
    logic [7:0]  rd_data, ad_out, ad_in, a_hi;

    // external memory model state
    logic [7:0] sram    [logic [15:0]];
    logic [7:0] exp_mem [logic [15:0]];
    logic [7:0] latch_q = '0;
    logic       sram_oe = 1'b0;
    logic [7:0] sram_dq = '0;

    assign ad_in = ad_oe ? ad_out : (sram_oe ? sram_dq : 8'hA5);

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    logic [15:0] cur_addr = '0;
    logic [7:0]  cur_wdata = '0;
    logic        cur_wr = 1'b0;
    logic [15:0] pool [16];

    muxbus_ctrl #(
        .AW(16), .DW(8), .ALE_CYC(ALE_C), .AHOLD_CYC(AH_C),
        .TURN_CYC(TR_C), .STRB_CYC(ST_C), .WHOLD_CYC(WH_C)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_idle(req_idle),
        .done(done), .rd_data(rd_data), .ad_out(ad_out), .ad_oe(ad_oe),
        .ad_in(ad_in), .a_hi(a_hi), .ale(ale), .rd_n(rd_n), .wr_n(wr_n)
    );

    always #10 clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int latency(input bit wr);
        return wr ? (ALE_C + AH_C + ST_C + WH_C + 1) : (ALE_C + AH_C + TR_C + ST_C + 1);
    endfunction

    function automatic logic [7:0] ref_rd(input logic [15:0] a);
        return exp_mem.exists(a) ? exp_mem[a] : 8'h00;
    endfunction

    // pin monitor and memory model, sampled mid-cycle
    logic       p_ale = 0, p_rd = 1, p_wr = 1, p_idle = 1, p_done = 0, p_oe = 0;
    logic [7:0] p_ahi = 0;
    int ale_run = 0, rd_run = 0, wr_run = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (ale) begin
                latch_q = ad_out;
                ale_run++;
                chk(ad_oe, "R3", "oe during ale", ad_oe, 1);
                chk(a_hi == cur_addr[15:8], "R3", "a_hi during ale", a_hi, cur_addr[15:8]);
            end
            if (p_ale && !ale) begin
                chk(ale_run == ALE_C, "R3", "ale width", ale_run, ALE_C);
                chk(latch_q == cur_addr[7:0], "R3", "latched low byte", latch_q, cur_addr[7:0]);
                chk(ad_oe && ad_out == latch_q, "R4", "addr held after ale fall", ad_out, latch_q);
                chk(a_hi == p_ahi, "R4", "a_hi held after ale fall", a_hi, p_ahi);
                ale_run = 0;
            end
            chk(!(!rd_n && !wr_n), "R5", "strobes both low", {rd_n, wr_n}, 3);
            if (ale) chk(rd_n && wr_n, "R5", "strobe during ale", {rd_n, wr_n}, 3);
            if (!rd_n) begin
                rd_run++;
                chk(!ad_oe, "R6", "oe during read strobe", ad_oe, 0);
                if (p_rd) chk(!p_oe, "R6", "release before rd", p_oe, 0);
            end
            if (!p_rd && rd_n) begin
                chk(rd_run == ST_C, "R6", "rd width", rd_run, ST_C);
                rd_run = 0;
            end
            sram_oe = !rd_n;
            if (!rd_n) sram_dq = sram.exists({a_hi, latch_q}) ? sram[{a_hi, latch_q}] : 8'h00;
            if (!wr_n) begin
                wr_run++;
                chk(ad_oe && ad_out == cur_wdata, "R7", "wr data", ad_out, cur_wdata);
            end
            if (!p_wr && wr_n) begin
                chk(wr_run == ST_C, "R7", "wr width", wr_run, ST_C);
                chk(ad_oe && ad_out == cur_wdata, "R7", "wr data hold", ad_out, cur_wdata);
                chk({a_hi, latch_q} == cur_addr, "R8", "write address", {a_hi, latch_q}, cur_addr);
                sram[{a_hi, latch_q}] = ad_out;
                wr_run = 0;
            end
            if (!req_idle && !p_idle)
                chk(a_hi == p_ahi, "R8", "a_hi steady", a_hi, p_ahi);
            if (done && p_done) chk(1'b0, "R9", "done longer than 1", 2, 1);
            if (req_idle) chk(!ad_oe, "R10", "oe while idle", ad_oe, 0);
            p_ale = ale; p_rd = rd_n; p_wr = wr_n; p_idle = req_idle;
            p_done = done; p_oe = ad_oe; p_ahi = a_hi;
        end
    end

    task automatic issue(input bit wr, input logic [15:0] a, input logic [7:0] wd);
        @(negedge clk);
        while (!req_idle) @(negedge clk);
        cur_wr = wr; cur_addr = a; cur_wdata = wd;
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Called on the first sampling point after acceptance (count 1).
    task automatic finish(input bit wr, input logic [15:0] a, input logic [7:0] wd,
                          input bit junk);
        int k = 1;
        while (!done && k < 40) begin
            if (junk && k == 2) begin
                req_valid = 1'b1; req_write = !wr; req_addr = ~a; req_wdata = ~wd;
            end
            if (junk && k == 5) req_valid = 1'b0;
            @(negedge clk);
            k++;
        end
        chk(k == latency(wr), "R9", "latency", k, latency(wr));
        if (wr) begin
            exp_mem[a] = wd;
            chk(sram.exists(a) && sram[a] == wd, "R7", "memory content", sram.exists(a) ? sram[a] : 0, wd);
        end else begin
            chk(rd_data == ref_rd(a), "R9", "read data", rd_data, ref_rd(a));
        end
        if (junk) begin
            for (int i = 0; i < 3; i++) begin
                @(negedge clk);
                chk(req_idle && !ale, "R2", "no access from busy request", {req_idle, ale}, 2);
            end
        end
    endtask

    task automatic access(input bit wr, input logic [15:0] a, input logic [7:0] wd,
                          input bit junk);
        issue(wr, a, wd);
        finish(wr, a, wd, junk);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk(req_idle && !ale && rd_n && wr_n && !ad_oe && !done, "R1", "reset outputs",
            {req_idle, ale, rd_n, wr_n, ad_oe, done}, 6'b101100);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_idle && !ale && rd_n && wr_n && !ad_oe && !done, "R1", "after release",
            {req_idle, ale, rd_n, wr_n, ad_oe, done}, 6'b101100);

        // directed corners: extreme addresses and patterns
        access(1'b1, 16'h0000, 8'h00, 1'b0);
        access(1'b1, 16'hFFFF, 8'hFF, 1'b0);
        access(1'b1, 16'h55AA, 8'h5A, 1'b0);
        access(1'b0, 16'hFFFF, 8'h00, 1'b0);
        access(1'b0, 16'h0000, 8'h00, 1'b0);
        access(1'b0, 16'h55AA, 8'h00, 1'b0);
        access(1'b0, 16'h1234, 8'h00, 1'b0);
        access(1'b1, 16'hA5C3, 8'h3C, 1'b1);
        access(1'b0, 16'hA5C3, 8'h00, 1'b1);

        // request raised in the completion cycle
        issue(1'b1, 16'h0F0F, 8'hC7);
        begin
            int k = 1;
            while (!done && k < 40) begin @(negedge clk); k++; end
            chk(k == latency(1'b1), "R9", "latency before chained request", k, latency(1'b1));
            exp_mem[16'h0F0F] = 8'hC7;
            cur_wr = 1'b0; cur_addr = 16'h0F0F; cur_wdata = 8'h00;
            req_valid = 1'b1; req_write = 1'b0; req_addr = 16'h0F0F; req_wdata = 8'h00;
            @(negedge clk);
            chk(req_idle && !ale, "R2", "request in done cycle not taken", {req_idle, ale}, 2);
            @(negedge clk);
            chk(ale && !req_idle, "R2", "request taken one cycle later", {req_idle, ale}, 1);
            req_valid = 1'b0;
            finish(1'b0, 16'h0F0F, 8'h00, 1'b0);
        end

        for (int i = 0; i < 16; i++) pool[i] = 16'($urandom);
        for (int n = 0; n < 300; n++) begin
            logic [15:0] a;
            a = pool[$urandom % 16];
            access(1'($urandom % 2), a, 8'($urandom), ($urandom % 5) == 0);
        end

        repeat (4) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == WD_LIMIT) begin
            failures++;
            $display("FAIL R9 watchdog actual=%0d expected=%0d", cyc, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule